// File: doc/BRIEF.md
# Byte-Organised Load/Store Data Memory

This block is a small synchronous data memory, organised in bytes, that serves one load or store request at a time from a processor's execute stage. A request carries a load strobe or a store strobe, a 3-bit size/sign code, a byte address, 32 bits of store data and a destination register number. Stores put 1, 2 or 4 bytes into the array in little-endian order. Loads gather 1, 2 or 4 bytes and sign-extend or zero-extend them to 32 bits. The result goes back with the destination register number and a one-cycle valid strobe, so a register file can write it.

Each accepted request occupies a fixed instruction step. The controller has four states:
- `ST_IDLE` accepts a request.
- `ST_HOLD` lasts `STEP_CYCLES` cycles.
- `ST_COMMIT` writes a store into the array when it exits.
- `ST_RETURN` presents load data.

The transitions are:
- IDLE→HOLD on a valid request.
- IDLE→IDLE on an invalid request, which sets the error flag.
- HOLD→COMMIT (store) or HOLD→RETURN (load) when the step count expires.
- COMMIT→IDLE and RETURN→IDLE unconditionally.

An invalid request is an undefined size code, both strobes together, or an access whose last byte lies beyond the array. It raises a sticky error flag and does nothing else.

Top module: `byte_lsu`

## Requirements
- R1: After reset, `busy`, `wb_valid` and `err_flag` are 0.
- R2: A byte store (code 000) writes bits 7:0 of the store data to the addressed byte only; neighbouring bytes keep their values.
- R3: A halfword store (code 001) writes bits 7:0 to address and bits 15:8 to address+1.
- R4: A word store (code 010) writes bits 7:0, 15:8, 23:16 and 31:24 to address, +1, +2 and +3.
- R5: A signed byte load (code 000) copies bit 7 into bits 31:8. An unsigned byte load (code 100) fills bits 31:8 with zeros.
- R6: A halfword load takes address as the low byte and address+1 as the high byte. It is sign-extended from bit 15 for code 001 and zero-extended for code 101.
- R7: A word load (code 010) returns the four bytes at address..address+3, with the byte at address in bits 7:0.
- R8: Timing of an accepted request:
  - A load raises `wb_valid` for exactly one cycle, STEP_CYCLES+1 cycles after the cycle in which it was presented, with `wb_rd` equal to the request's register number.
  - A store never raises `wb_valid`.
  - `busy` stays high for STEP_CYCLES+1 cycles.
- R9: A size code other than 000, 001, 010, 100, 101 for a load, or other than 000, 001, 010 for a store, or both strobes together, sets `err_flag`. Such a request is not accepted (no `busy`, no `wb_valid`) and writes nothing.
- R10: An access whose last byte address is at or beyond DEPTH sets `err_flag`, writes nothing and returns nothing.
- R11: A request presented while `busy` is high is ignored.
- R12: `err_flag` stays set through later valid requests until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | Load request strobe |
| req_store | input | 1 | Store request strobe |
| req_size | input | 3 | Size/sign code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data |
| req_rd | input | RW | Destination register number |
| busy | output | 1 | A request is in progress |
| wb_valid | output | 1 | Load result valid (one cycle) |
| wb_data | output | 32 | Extended load result |
| wb_rd | output | RW | Destination register of the load result |
| err_flag | output | 1 | Sticky error flag |

## Verification
The bench reads back each store with every load width, so the following faults show up as wrong words:
- a swapped byte lane;
- an upper byte taken from the wrong address;
- sign extension from the wrong bit.

It counts cycles to `wb_valid` and cycles of `busy`, which catches a step counter that is off by one or a store that also raises the write-back strobe. Four boundary cases are probed:
- A word at the last four bytes must succeed, while a halfword at the very last byte must fail without a write. A design that wraps the address would corrupt byte 0 or accept the request.
- A request injected mid-step must not land, which catches a controller that re-accepts while busy.
- Undefined size codes and double strobes must leave memory intact.
- The error flag must persist across good requests and clear only on reset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_RETURN = 2'd3
    } lsu_state_t;

    localparam logic [2:0] SZ_BYTE   = 3'b000;
    localparam logic [2:0] SZ_HALF   = 3'b001;
    localparam logic [2:0] SZ_WORD   = 3'b010;
    localparam logic [2:0] SZ_BYTE_U = 3'b100;
    localparam logic [2:0] SZ_HALF_U = 3'b101;

    // Number of bytes moved by a size code (0 for undefined codes)
    function automatic logic [2:0] bytes_for(input logic [2:0] sz);
        unique case (sz)
            SZ_BYTE, SZ_BYTE_U: bytes_for = 3'd1;
            SZ_HALF, SZ_HALF_U: bytes_for = 3'd2;
            SZ_WORD:            bytes_for = 3'd4;
            default:            bytes_for = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 64
) (
    input  logic          is_load,
    input  logic          is_store,
    input  logic [2:0]    size,
    input  logic [AW-1:0] addr,
    output logic          req_ok,
    output logic [2:0]    nbytes
);
    logic          size_ok;
    logic          range_ok;
    logic [AW:0]   last_byte;

    always_comb begin
        nbytes = bytes_for(size);
        if (is_load && !is_store)
            size_ok = (nbytes != 3'd0);
        else if (is_store && !is_load)
            size_ok = (size == SZ_BYTE) || (size == SZ_HALF) || (size == SZ_WORD);
        else
            size_ok = 1'b0;
        last_byte = {1'b0, addr} + (AW+1)'(nbytes) - (AW+1)'(1);
        range_ok  = (nbytes != 3'd0) && (last_byte < (AW+1)'(DEPTH));
        req_ok    = size_ok && range_ok;
    end
endmodule

// File: rtl/lsu_bytes.sv
module lsu_bytes #(
    parameter int AW    = 32,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    wr_n,
    input  logic [31:0]   wr_data,
    output logic [31:0]   rd_word
);
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LANES = 4;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (3'(i) < wr_n)
                    mem[IW'(addr + AW'(i))] <= wr_data[8*i +: 8];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW:0] lane_addr;
        assign lane_addr = {1'b0, addr} + (AW+1)'(g);
        assign rd_word[8*g +: 8] = (lane_addr < (AW+1)'(DEPTH)) ? mem[IW'(lane_addr)] : 8'h00;
    end

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (({1'b0, addr} + (AW+1)'(wr_n)) <= (AW+1)'(DEPTH))); // R10
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_n == 3'd1 || wr_n == 3'd2 || wr_n == 3'd4)); // R4
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
    import lsu_pkg::*;
(
    input  logic [2:0]  size,
    input  logic [31:0] raw,
    output logic [31:0] value
);
    always_comb begin
        unique case (size)
            SZ_BYTE:   value = {{24{raw[7]}}, raw[7:0]};
            SZ_BYTE_U: value = {24'h0, raw[7:0]};
            SZ_HALF:   value = {{16{raw[15]}}, raw[15:0]};
            SZ_HALF_U: value = {16'h0, raw[15:0]};
            SZ_WORD:   value = raw;
            default:   value = 32'h0;
        endcase
    end
endmodule

// File: rtl/byte_lsu.sv
module byte_lsu
    import lsu_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DEPTH       = 64,
    parameter int STEP_CYCLES = 4,
    parameter int RW          = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_load,
    input  logic          req_store,
    input  logic [2:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    input  logic [RW-1:0] req_rd,
    output logic          busy,
    output logic          wb_valid,
    output logic [31:0]   wb_data,
    output logic [RW-1:0] wb_rd,
    output logic          err_flag
);
    localparam int CW = $clog2(STEP_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(STEP_CYCLES - 1);

    lsu_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    logic          lat_load;
    logic [2:0]    lat_size;
    logic [AW-1:0] lat_addr;
    logic [31:0]   lat_data;
    logic [RW-1:0] lat_rd;
    logic [31:0]   wb_data_q;
    logic          err_q;

    logic          new_req;
    logic          req_ok;
    logic [2:0]    req_n;
    logic          accept;
    logic          step_end;
    logic [31:0]   rd_word;
    logic [31:0]   ext_word;

    assign new_req  = (state == ST_IDLE) && (req_load || req_store);
    assign accept   = new_req && req_ok;
    assign step_end = (state == ST_HOLD) && (cnt == LAST_CNT);

    lsu_decode #(.AW(AW), .DEPTH(DEPTH)) u_decode (
        .is_load  (req_load),
        .is_store (req_store),
        .size     (req_size),
        .addr     (req_addr),
        .req_ok   (req_ok),
        .nbytes   (req_n)
    );

    lsu_bytes #(.AW(AW), .DEPTH(DEPTH)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state == ST_COMMIT),
        .addr    (lat_addr),
        .wr_n    (bytes_for(lat_size)),
        .wr_data (lat_data),
        .rd_word (rd_word)
    );

    lsu_extend u_extend (
        .size  (lat_size),
        .raw   (rd_word),
        .value (ext_word)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_HOLD;
            ST_HOLD:   if (step_end) state_nx = lat_load ? ST_RETURN : ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_RETURN: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lat_load  <= 1'b0;
            lat_size  <= SZ_BYTE;
            lat_addr  <= '0;
            lat_data  <= '0;
            lat_rd    <= '0;
            wb_data_q <= '0;
            err_q     <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cnt      <= '0;
                lat_load <= req_load;
                lat_size <= req_size;
                lat_addr <= req_addr;
                lat_data <= req_wdata;
                lat_rd   <= req_rd;
            end else if (state == ST_HOLD) begin
                cnt <= cnt + CW'(1);
            end
            if (new_req && !req_ok)
                err_q <= 1'b1;
            if (step_end && lat_load)
                wb_data_q <= ext_word;
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        wb_valid = (state == ST_RETURN);
        wb_data  = wb_data_q;
        wb_rd    = lat_rd;
        err_flag = err_q;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R12
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R8
    AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (req_load || req_store) && !req_ok) |=> (!busy && err_flag)); // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data) && $stable(lat_rd))); // R11
endmodule

// File: tb/byte_lsu_bench.sv
module byte_lsu_bench;
    localparam int AW = 32;
    localparam int DEPTH = 64;
    localparam int STEP = 4;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_load = 1'b0;
    logic          req_store = 1'b0;
    logic [2:0]    req_size = 3'b000;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [RW-1:0] req_rd = '0;
    logic          busy;
    logic          wb_valid;
    logic [31:0]   wb_data;
    logic [RW-1:0] wb_rd;
    logic          err_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int          got_wb;
    int          got_lat;
    int          got_busy;
    logic [31:0] got_data;
    logic [RW-1:0] got_rd;

    always #2.5 clk = ~clk;

    byte_lsu #(.AW(AW), .DEPTH(DEPTH), .STEP_CYCLES(STEP), .RW(RW)) u_byte_lsu (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .req_rd(req_rd),
        .busy(busy), .wb_valid(wb_valid), .wb_data(wb_data), .wb_rd(wb_rd), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request for one cycle; observe 12 following cycles
    task automatic op(input logic ld, input logic st, input logic [2:0] sz,
                      input logic [31:0] a, input logic [31:0] d, input logic [RW-1:0] rd);
        got_wb = 0; got_lat = 0; got_busy = 0; got_data = '0; got_rd = '0;
        @(negedge clk);
        req_load = ld; req_store = st; req_size = sz; req_addr = a; req_wdata = d; req_rd = rd;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 1) begin req_load = 1'b0; req_store = 1'b0; end
            if (busy) got_busy++;
            if (wb_valid) begin
                got_wb++; got_lat = k; got_data = wb_data; got_rd = wb_rd;
            end
        end
    endtask

    task automatic load_chk(input string req, input logic [2:0] sz, input logic [31:0] a,
                            input logic [31:0] exp);
        op(1'b1, 1'b0, sz, a, 32'h0, 5'd9);
        chk(req, got_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        chk("R1 err_flag", 32'(err_flag), 32'd0);
    endtask

    task automatic t_word();
        op(1'b0, 1'b1, 3'b010, 32'd4, 32'h8899AABB, 5'd0);
        chk("R8 store busy cycles", 32'(got_busy), 32'(STEP + 1));
        chk("R8 store no wb", 32'(got_wb), 32'd0);
        op(1'b1, 1'b0, 3'b010, 32'd4, 32'h0, 5'd7);
        chk("R7 word load", got_data, 32'h8899AABB);
        chk("R4 word store order", got_data, 32'h8899AABB);
        chk("R8 load latency", 32'(got_lat), 32'(STEP + 1));
        chk("R8 single wb pulse", 32'(got_wb), 32'd1);
        chk("R8 wb_rd", 32'(got_rd), 32'd7);
        chk("R8 load busy cycles", 32'(got_busy), 32'(STEP + 1));
    endtask

    task automatic t_bytes();
        load_chk("R5 LB negative", 3'b000, 32'd4, 32'hFFFFFFBB);
        load_chk("R5 LBU", 3'b100, 32'd4, 32'h000000BB);
        load_chk("R5 LB addr+1", 3'b000, 32'd5, 32'hFFFFFFAA);
        load_chk("R5 LB addr+3", 3'b000, 32'd7, 32'hFFFFFF88);
        op(1'b0, 1'b1, 3'b010, 32'd8, 32'h0, 5'd0);
        op(1'b0, 1'b1, 3'b000, 32'd8, 32'h1234567F, 5'd0);
        load_chk("R2 byte store only", 3'b010, 32'd8, 32'h0000007F);
        load_chk("R5 LB positive", 3'b000, 32'd8, 32'h0000007F);
    endtask

    task automatic t_half();
        load_chk("R6 LH", 3'b001, 32'd4, 32'hFFFFAABB);
        load_chk("R6 LHU upper", 3'b101, 32'd6, 32'h00008899);
        op(1'b0, 1'b1, 3'b010, 32'd12, 32'hFFFFFFFF, 5'd0);
        op(1'b0, 1'b1, 3'b001, 32'd12, 32'hCAFE8001, 5'd0);
        load_chk("R3 half store", 3'b010, 32'd12, 32'hFFFF8001);
        load_chk("R6 LH sign", 3'b001, 32'd12, 32'hFFFF8001);
        load_chk("R6 LHU zero", 3'b101, 32'd12, 32'h00008001);
    endtask

    task automatic t_edge_word();
        op(1'b0, 1'b1, 3'b010, 32'(DEPTH - 4), 32'h01020304, 5'd0);
        chk("R10 last word accepted", 32'(err_flag), 32'd0);
        load_chk("R4 last word", 3'b010, 32'(DEPTH - 4), 32'h01020304);
    endtask

    task automatic t_busy_ignore();
        op(1'b0, 1'b1, 3'b010, 32'd20, 32'h0, 5'd0);
        op(1'b0, 1'b1, 3'b000, 32'd20, 32'h5A, 5'd0);
        @(negedge clk);
        req_store = 1'b1; req_size = 3'b000; req_addr = 32'd21; req_wdata = 32'h11;
        @(negedge clk);
        req_store = 1'b0;
        @(negedge clk);
        req_store = 1'b1; req_addr = 32'd20; req_wdata = 32'h22;
        @(negedge clk);
        req_store = 1'b0;
        repeat (10) @(negedge clk);
        load_chk("R11 request while busy ignored", 3'b010, 32'd20, 32'h0000115A);
    endtask

    task automatic t_bad_size();
        op(1'b0, 1'b1, 3'b011, 32'd4, 32'h0, 5'd0);
        chk("R9 err set", 32'(err_flag), 32'd1);
        chk("R9 not busy", 32'(got_busy), 32'd0);
        op(1'b0, 1'b1, 3'b100, 32'd4, 32'h0, 5'd0);
        op(1'b1, 1'b1, 3'b010, 32'd4, 32'h0, 5'd0);
        op(1'b1, 1'b0, 3'b110, 32'd4, 32'h0, 5'd3);
        chk("R9 bad load no wb", 32'(got_wb), 32'd0);
        load_chk("R9 memory untouched", 3'b010, 32'd4, 32'h8899AABB);
        chk("R12 err kept", 32'(err_flag), 32'd1);
        do_reset();
        chk("R12 err cleared by reset", 32'(err_flag), 32'd0);
    endtask

    task automatic t_range();
        op(1'b0, 1'b1, 3'b001, 32'(DEPTH - 1), 32'hFFFF, 5'd0);
        chk("R10 err set", 32'(err_flag), 32'd1);
        chk("R10 not busy", 32'(got_busy), 32'd0);
        load_chk("R10 last byte untouched", 3'b100, 32'(DEPTH - 1), 32'h00000001);
        load_chk("R10 byte 0 untouched", 3'b100, 32'd0, 32'h00000000);
        op(1'b1, 1'b0, 3'b010, 32'(DEPTH - 2), 32'h0, 5'd4);
        chk("R10 load no wb", 32'(got_wb), 32'd0);
    endtask

    initial begin
        do_reset();
        t_reset();
        op(1'b0, 1'b1, 3'b010, 32'd0, 32'h0, 5'd0);
        t_word();
        t_bytes();
        t_half();
        t_edge_word();
        t_busy_ignore();
        t_bad_size();
        t_range();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule